// File: doc/BRIEF.md
# Run-Time Programmable Capture Condition Evaluator

This block decides, once per clock, whether a group of watched probe buses satisfies a filter condition that software can rewrite while the design runs. Each probe bus has its own slot. A slot holds an enable, a relational operator, a compare value and a care mask. Instead of the relational test, a slot can run an edge test on bit 0 of its probe. That test compares the present sample of the bit with the sample taken one clock earlier.

The results of the enabled slots are merged with a single global operator, which is either all-AND or all-OR and is never a mix of the two. The merged result is registered as a single match flag. A data-capture engine can use the flag to decide which samples to keep. The configuration is loaded through a simple single-cycle register write port.

Top module: `capture_cond_eval`

## Requirements
- R1: After reset the match output is 0, every slot is disabled and the global operator is AND.
- R2: Register map, with `cfgAddr = 4*s + field` for slot `s`. Field 0 is control, where bit 0 is enable, bits 3:1 are the operator and bits 5:4 are the edge mode. Field 1 is the compare value and field 2 is the care mask. Address `4*NUM_SLOTS` is the global register, where bit 0 set selects OR and bit 0 clear selects AND.
- R3: In level mode (edge mode 0) the operator codes are 0 equal, 1 not equal, 2 greater than, 3 greater or equal, 4 less than and 5 less or equal. All of them compare probe against value as unsigned numbers. Codes 6 and 7 are never true.
- R4: Before any relational comparison, both probe and value are ANDed with the care mask, so bits whose mask is 0 do not matter. For example, value 101 with mask 101 matches probe 101 and probe 111.
- R5: Edge mode 1 is true when probe bit 0 rose since the previous clock. Mode 2 is true when it fell, and mode 3 is true on either change. In an edge mode the operator, value and mask have no effect.
- R6: With AND, match is 1 only when every enabled slot is true in the same cycle.
- R7: With OR, match is 1 when at least one enabled slot is true.
- R8: Disabled slots take no part in the result. When no slot is enabled, match is 0.
- R9: Match is registered. The value it shows in a cycle reflects the probes and configuration present during the previous clock edge.
- R10: A write to field 3 of any slot, or to any address above the global register, changes no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | $clog2(4*NUM_SLOTS+1) | Configuration register address |
| cfgWrData | input | max(PROBE_W,6) | Configuration write data |
| probes | input | NUM_SLOTS*PROBE_W | Probe buses, slot s at bits s*PROBE_W upward |
| match | output | 1 | Registered capture condition result |

## Verification
The bench walks every operator code across the values just below, at and just above the compare value. A swapped or off-by-one comparison, or an illegal code that reads as true, would flip the match at one of those three points. Mask tests apply the don't-care bits so that a design masking only one operand, or none, gives a wrong answer. The edge tests set a level compare that can never succeed, so a design that leaks the operator into edge mode, or compares against the wrong previous sample, shows a spurious or missing match.

The AND and OR tests include a disabled slot whose value would change the outcome. A latency probe checks that the flag does not move before the clock edge. Writes to unmapped addresses are followed by a probe pattern whose result would differ if they had landed.

// File: rtl/cce_pkg.sv
package cce_pkg;
  localparam int FIELDS_PER_SLOT = 4;
  localparam logic [1:0] FIELD_CTRL  = 2'd0;
  localparam logic [1:0] FIELD_VALUE = 2'd1;
  localparam logic [1:0] FIELD_MASK  = 2'd2;

  localparam logic [2:0] OP_EQ = 3'd0;
  localparam logic [2:0] OP_NE = 3'd1;
  localparam logic [2:0] OP_GT = 3'd2;
  localparam logic [2:0] OP_GE = 3'd3;
  localparam logic [2:0] OP_LT = 3'd4;
  localparam logic [2:0] OP_LE = 3'd5;

  typedef enum logic [1:0] {
    EDGE_LEVEL = 2'd0,
    EDGE_RISE  = 2'd1,
    EDGE_FALL  = 2'd2,
    EDGE_ANY   = 2'd3
  } edgeModeE;

  typedef struct packed {
    logic     enable;
    logic [2:0] op;
    edgeModeE edgeMode;
  } slotCfgT;

  typedef struct packed {
    logic combineOr;
    logic anyEnabled;
  } ctrlStrobeT;
endpackage

// File: rtl/cce_slot_cmp.sv
module cce_slot_cmp
  import cce_pkg::*;
#(
  parameter int PROBE_W = 8
) (
  input  logic [PROBE_W-1:0] probe,
  input  logic               prevBit,
  input  slotCfgT            cfg,
  input  logic [PROBE_W-1:0] cmpValue,
  input  logic [PROBE_W-1:0] careMask,
  output logic               hit
);
  logic [PROBE_W-1:0] aMasked;
  logic [PROBE_W-1:0] bMasked;
  logic relHit;
  logic curBit;

  always_comb begin
    aMasked = probe & careMask;
    bMasked = cmpValue & careMask;
    case (cfg.op)
      OP_EQ:   relHit = (aMasked == bMasked);
      OP_NE:   relHit = (aMasked != bMasked);
      OP_GT:   relHit = (aMasked >  bMasked);
      OP_GE:   relHit = (aMasked >= bMasked);
      OP_LT:   relHit = (aMasked <  bMasked);
      OP_LE:   relHit = (aMasked <= bMasked);
      default: relHit = 1'b0;
    endcase
  end

  assign curBit = probe[0];

  always_comb begin
    case (cfg.edgeMode)
      EDGE_LEVEL: hit = relHit;
      EDGE_RISE:  hit = curBit & ~prevBit;
      EDGE_FALL:  hit = ~curBit & prevBit;
      default:    hit = curBit ^ prevBit;
    endcase
  end
endmodule

// File: rtl/cce_ctrl.sv
module cce_ctrl
  import cce_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int PROBE_W   = 8,
  parameter int ADDR_W    = 5,
  parameter int CFG_W     = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              cfgWrEn,
  input  logic [ADDR_W-1:0]                 cfgAddr,
  input  logic [CFG_W-1:0]                  cfgWrData,
  output slotCfgT [NUM_SLOTS-1:0]           slotCfg,
  output logic [NUM_SLOTS-1:0][PROBE_W-1:0] cmpValue,
  output logic [NUM_SLOTS-1:0][PROBE_W-1:0] careMask,
  output ctrlStrobeT                        strobes
);
  localparam int SLOT_IDX_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] GLOBAL_ADDR = ADDR_W'(NUM_SLOTS * FIELDS_PER_SLOT);

  logic [1:0]            fieldSel;
  logic [SLOT_IDX_W-1:0] slotIdx;
  logic                  combineOrQ;
  logic [NUM_SLOTS-1:0]  enBits;

  assign fieldSel = cfgAddr[1:0];
  assign slotIdx  = cfgAddr[ADDR_W-1:2];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slotRegs
    logic slotWr;
    assign slotWr = cfgWrEn && (slotIdx == SLOT_IDX_W'(s));
    assign enBits[s] = slotCfg[s].enable;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotCfg[s]  <= '0;
        cmpValue[s] <= '0;
        careMask[s] <= '1;
      end else if (slotWr) begin
        case (fieldSel)
          FIELD_CTRL: begin
            slotCfg[s].enable   <= cfgWrData[0];
            slotCfg[s].op       <= cfgWrData[3:1];
            slotCfg[s].edgeMode <= edgeModeE'(cfgWrData[5:4]);
          end
          FIELD_VALUE: cmpValue[s] <= cfgWrData[PROBE_W-1:0];
          FIELD_MASK:  careMask[s] <= cfgWrData[PROBE_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) combineOrQ <= 1'b0;
    else if (cfgWrEn && cfgAddr == GLOBAL_ADDR) combineOrQ <= cfgWrData[0];
  end

  assign strobes.combineOr  = combineOrQ;
  assign strobes.anyEnabled = |enBits;

  logic addrMapped;
  assign addrMapped = (cfgAddr < GLOBAL_ADDR && fieldSel != 2'd3) || (cfgAddr == GLOBAL_ADDR);

  // R2
  global_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == GLOBAL_ADDR) |=> (strobes.combineOr == $past(cfgWrData[0])));

  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !addrMapped) |=> $stable({slotCfg, cmpValue, careMask, strobes}));
endmodule

// File: rtl/cce_datapath.sv
module cce_datapath
  import cce_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int PROBE_W   = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_SLOTS*PROBE_W-1:0]      probes,
  input  slotCfgT [NUM_SLOTS-1:0]           slotCfg,
  input  logic [NUM_SLOTS-1:0][PROBE_W-1:0] cmpValue,
  input  logic [NUM_SLOTS-1:0][PROBE_W-1:0] careMask,
  input  ctrlStrobeT                        strobes,
  output logic                              matchQ
);
  logic [NUM_SLOTS-1:0] prevBit;
  logic [NUM_SLOTS-1:0] slotHit;
  logic [NUM_SLOTS-1:0] enMask;
  logic andHit;
  logic orHit;
  logic matchNext;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [PROBE_W-1:0] probeSlice;
    assign probeSlice = probes[s*PROBE_W +: PROBE_W];
    assign enMask[s]  = slotCfg[s].enable;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevBit[s] <= 1'b0;
      else       prevBit[s] <= probeSlice[0];
    end

    cce_slot_cmp #(.PROBE_W(PROBE_W)) i_cmp (
      .probe    (probeSlice),
      .prevBit  (prevBit[s]),
      .cfg      (slotCfg[s]),
      .cmpValue (cmpValue[s]),
      .careMask (careMask[s]),
      .hit      (slotHit[s])
    );
  end

  assign andHit    = &(slotHit | ~enMask);
  assign orHit     = |(slotHit & enMask);
  assign matchNext = strobes.anyEnabled && (strobes.combineOr ? orHit : andHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchQ <= 1'b0;
    else       matchQ <= matchNext;
  end

  // R8
  idle_no_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.anyEnabled |=> !matchQ);

  // R6
  and_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.combineOr && |(enMask & ~slotHit)) |=> !matchQ);

  // R7
  or_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.combineOr && |(enMask & slotHit)) |=> matchQ);
endmodule

// File: rtl/capture_cond_eval.sv
module capture_cond_eval
  import cce_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int PROBE_W   = 8,
  localparam int ADDR_W   = $clog2(NUM_SLOTS * FIELDS_PER_SLOT + 1),
  localparam int CFG_W    = (PROBE_W > 6) ? PROBE_W : 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWrEn,
  input  logic [ADDR_W-1:0]            cfgAddr,
  input  logic [CFG_W-1:0]             cfgWrData,
  input  logic [NUM_SLOTS*PROBE_W-1:0] probes,
  output logic                         match
);
  slotCfgT [NUM_SLOTS-1:0]           slotCfg;
  logic [NUM_SLOTS-1:0][PROBE_W-1:0] cmpValue;
  logic [NUM_SLOTS-1:0][PROBE_W-1:0] careMask;
  ctrlStrobeT                        strobes;

  cce_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .PROBE_W(PROBE_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .slotCfg   (slotCfg),
    .cmpValue  (cmpValue),
    .careMask  (careMask),
    .strobes   (strobes)
  );

  cce_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .PROBE_W(PROBE_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .probes   (probes),
    .slotCfg  (slotCfg),
    .cmpValue (cmpValue),
    .careMask (careMask),
    .strobes  (strobes),
    .matchQ   (match)
  );
endmodule

// File: tb/test_capture_cond_eval.sv
module test_capture_cond_eval;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [4:0] cfgAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] pr [4];
  logic [31:0] probes;
  logic       match;
  int checks = 0;
  int errors = 0;

  assign probes = {pr[3], pr[2], pr[1], pr[0]};

  always #5 clk = ~clk;

  capture_cond_eval i_capture_cond_eval (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .probes(probes), .match(match)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: match=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic writeReg(input int addr, input logic [7:0] data);
    cfgWrEn = 1'b1; cfgAddr = 5'(addr); cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  function automatic logic [7:0] ctrlWord(input logic en, input int op, input int edgeMode);
    return {2'b00, 2'(edgeMode), 3'(op), en};
  endfunction

  function automatic logic expRel(input int op, input logic [7:0] a, input logic [7:0] b);
    case (op)
      0: return a == b;
      1: return a != b;
      2: return a > b;
      3: return a >= b;
      4: return a < b;
      5: return a <= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sampleCheck(input logic exp, input string tag);
    @(negedge clk);
    check(match, exp, tag);
  endtask

  task automatic clearAll();
    for (int s = 0; s < 4; s++) begin
      writeReg(4*s, 8'h00);
      writeReg(4*s+2, 8'hFF);
    end
    writeReg(16, 8'h00);
  endtask

  task automatic t_reset();
    for (int s = 0; s < 4; s++) pr[s] = 8'hFF;
    sampleCheck(1'b0, "R1 reset match low");
    for (int s = 0; s < 4; s++) pr[s] = 8'h00;
    sampleCheck(1'b0, "R8 no slot enabled");
  endtask

  task automatic t_ops();
    logic [7:0] vals [3] = '{8'h3F, 8'h40, 8'h41};
    clearAll();
    writeReg(1, 8'h40);
    for (int op = 0; op < 8; op++) begin
      writeReg(0, ctrlWord(1'b1, op, 0));
      for (int i = 0; i < 3; i++) begin
        pr[0] = vals[i];
        sampleCheck(expRel(op, vals[i], 8'h40), $sformatf("R3 op%0d probe %h", op, vals[i]));
      end
    end
  endtask

  task automatic t_mask();
    clearAll();
    writeReg(1, 8'b0000_0101);
    writeReg(2, 8'b0000_0101);
    writeReg(0, ctrlWord(1'b1, 0, 0));
    pr[0] = 8'b101;  sampleCheck(1'b1, "R4 1X1 vs 101");
    pr[0] = 8'b111;  sampleCheck(1'b1, "R4 1X1 vs 111");
    pr[0] = 8'b100;  sampleCheck(1'b0, "R4 1X1 vs 100");
    pr[0] = 8'hFD;   sampleCheck(1'b1, "R4 upper bits ignored");
    writeReg(1, 8'h0F);
    writeReg(2, 8'hF0);
    writeReg(0, ctrlWord(1'b1, 2, 0));
    pr[0] = 8'h1F;   sampleCheck(1'b1, "R4 masked greater");
    pr[0] = 8'h0F;   sampleCheck(1'b0, "R4 masked equal not greater");
  endtask

  task automatic t_edge();
    clearAll();
    pr[1] = 8'h00;
    writeReg(5, 8'hFF);
    writeReg(6, 8'h00);
    writeReg(4, ctrlWord(1'b1, 2, 1));
    pr[1] = 8'h00; sampleCheck(1'b0, "R5 rise steady low");
    pr[1] = 8'h01; sampleCheck(1'b1, "R5 rise");
    pr[1] = 8'hFF; sampleCheck(1'b0, "R5 rise steady high");
    pr[1] = 8'h00; sampleCheck(1'b0, "R5 rise on fall");
    writeReg(4, ctrlWord(1'b1, 2, 2));
    pr[1] = 8'h01; sampleCheck(1'b0, "R5 fall on rise");
    pr[1] = 8'hFE; sampleCheck(1'b1, "R5 fall");
    writeReg(4, ctrlWord(1'b1, 2, 3));
    pr[1] = 8'h01; sampleCheck(1'b1, "R5 any rise");
    pr[1] = 8'h03; sampleCheck(1'b0, "R5 any steady");
    pr[1] = 8'h00; sampleCheck(1'b1, "R5 any fall");
  endtask

  task automatic t_combine();
    clearAll();
    writeReg(1, 8'h10);  writeReg(0, ctrlWord(1'b1, 0, 0));
    writeReg(5, 8'h20);  writeReg(4, ctrlWord(1'b1, 0, 0));
    writeReg(9, 8'h80);  writeReg(8, ctrlWord(1'b1, 3, 0));
    writeReg(13, 8'h55); writeReg(12, ctrlWord(1'b0, 0, 0));
    pr[0] = 8'h10; pr[1] = 8'h20; pr[2] = 8'h90; pr[3] = 8'h00;
    sampleCheck(1'b1, "R6 all enabled true, disabled false (R8)");
    pr[1] = 8'h21;
    sampleCheck(1'b0, "R6 one enabled false");
    writeReg(16, 8'h01);
    pr[0] = 8'h00; pr[1] = 8'h00; pr[2] = 8'h80; pr[3] = 8'h00;
    sampleCheck(1'b1, "R7 one enabled true");
    pr[2] = 8'h7F;
    sampleCheck(1'b0, "R7 none true");
    pr[3] = 8'h55;
    sampleCheck(1'b0, "R8 only disabled slot true");
  endtask

  task automatic t_latency();
    clearAll();
    writeReg(1, 8'h33);
    writeReg(0, ctrlWord(1'b1, 0, 0));
    pr[0] = 8'h00;
    sampleCheck(1'b0, "R9 baseline");
    pr[0] = 8'h33;
    #2 check(match, 1'b0, "R9 no change before edge");
    @(negedge clk); check(match, 1'b1, "R9 set after edge");
    pr[0] = 8'h00;
    #2 check(match, 1'b1, "R9 held before edge");
    @(negedge clk); check(match, 1'b0, "R9 clear after edge");
  endtask

  task automatic t_unmapped();
    clearAll();
    writeReg(1, 8'h33); writeReg(0, ctrlWord(1'b1, 0, 0));
    writeReg(5, 8'h44); writeReg(4, ctrlWord(1'b1, 0, 0));
    writeReg(3, 8'hFF);
    writeReg(7, 8'hFF);
    writeReg(17, 8'hFF);
    writeReg(20, 8'hFF);
    writeReg(31, 8'hFF);
    pr[0] = 8'h33; pr[1] = 8'h00; pr[2] = 8'h00; pr[3] = 8'h00;
    sampleCheck(1'b0, "R10 AND kept after unmapped writes");
    pr[1] = 8'h44;
    sampleCheck(1'b1, "R10 values kept after unmapped writes");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: match=%0b expected=done", match);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) pr[s] = 8'h00;
    repeat (3) @(negedge clk);
    check(match, 1'b0, "R1 match low in reset");
    rstN = 1'b1;
    t_reset();
    t_ops();
    t_mask();
    t_edge();
    t_combine();
    t_latency();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule